// File: doc/BRIEF.md
# Dual-Resolution System Time Base

This block keeps the system time in one 34-bit counter. The counter advances by one every twelve input clocks. With the intended 48 MHz input clock, one count is 250 ns. Software and neighbouring logic see the count through two 32-bit windows:

- a fine window made of the low 32 bits;
- a coarse window made of the top 32 bits, so that one step of the coarse window is one microsecond.

A 16-bit select register picks a set of count bits between bit 2 and bit 17. Their OR drives an event line, which gives a programmable square wave or periodic trigger.

The counter does not start at reset. It waits for a rising edge on a slow tick input and aligns its prescaler to that edge. From that point on it counts. A status flag reports whether an alignment is still pending. A single-cycle write strobe requests a fresh alignment on the next slow edge, and the count value is kept through it. A debugger halt input can freeze the time base, but only when the halt-control input permits it. When the 34-bit value wraps to zero, the block emits a one-cycle overflow pulse.

Top module: `sys_time_base`

## Requirements
- R1: While `rstN` is low, the count is 0, `syncBusy` is 1, and `running`, `timeEvent` and `ovfPulse` are 0.
- R2: Before the first alignment the count holds at 0, however many clocks pass.
- R3: Let k be the first rising clock edge that samples `slowTick` high after it was low, while `syncBusy` is 1. At edge k+2 the prescaler restarts and `syncBusy` drops to 0. The count first increments 12 edges after that, and every 12 edges from then on.
- R4: `fineView` equals count bits [31:0] and `coarseView` equals count bits [33:2].
- R5: A `selWe` pulse loads `selWdata` into the select register at the next edge. `timeEvent` is the OR of count bit k+2 over every select bit k that is set. A select value of 0 holds `timeEvent` at 0.
- R6: A `resyncWr` pulse sets `syncBusy` to 1 at the next edge and leaves the count unchanged. The next qualifying slow edge then realigns as in R3. Slow edges seen while `syncBusy` is 0 have no effect on count timing.
- R7: `running` is 1 exactly when the time base has aligned at least once and is not frozen.
- R8: While `haltEn` and `haltReq` are both 1, the count and the prescaler phase hold. Counting resumes from the same phase when either input drops.
- R9: With `haltEn` at 0, `haltReq` has no effect, and the count advances by one every 12 clocks.
- R10: When the count wraps from all ones to zero, `ovfPulse` is 1 for exactly the one cycle in which the count reads zero. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock (divided by 12 for each count) |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | Low-frequency reference tick, synchronised inside the block |
| resyncWr | input | 1 | One-cycle request for a new alignment |
| haltEn | input | 1 | Allows the debugger halt to freeze counting |
| haltReq | input | 1 | Debugger halt request |
| selWe | input | 1 | Write strobe for the event select register |
| selWdata | input | SEL_W | New value for the event select register |
| fineView | output | VIEW_W | Count bits [VIEW_W-1:0] |
| coarseView | output | VIEW_W | Count bits [VIEW_W+1:2] |
| timeEvent | output | 1 | OR of the selected count bits |
| ovfPulse | output | 1 | One-cycle pulse on counter wrap |
| syncBusy | output | 1 | 1 while an alignment is pending |
| running | output | 1 | Aligned and not frozen |

## Verification
The count, both windows and `timeEvent` change at the rising edge that the prescaler selects. `syncBusy` clears two edges after the slow tick is first sampled high, and sets on the edge after `resyncWr`. `ovfPulse` appears in the same cycle as the zero count, while `running` follows the halt inputs in the same cycle. The bench drives inputs and compares outputs on the falling edge, and a reference model advances on the rising edge. Every expected value is therefore the state after the last rising edge. Directed checks count edges explicitly, for example the k+2 alignment and the 12-edge first step. A second, narrow instance reaches its wrap within the run, so the overflow timing can be checked against the alignment cycle.

// File: rtl/systime_pkg.sv
package systime_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic step;   // advance the count this cycle
  } ctrl_strobe_t;
endpackage

// File: rtl/systime_ctrl.sv
module systime_ctrl
  import systime_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         slowTick,
  input  logic         resyncWr,
  input  logic         haltEn,
  input  logic         haltReq,
  output ctrl_strobe_t strobe,
  output logic         syncBusy,
  output logic         running
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [SYNC_STAGES:0] tickHist;
  logic [PRE_W-1:0]     pre;
  logic                 initialised;
  logic                 tickEdge;
  logic                 frozen;
  logic                 alignNow;

  // synchroniser plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickHist <= '0;
    else       tickHist <= {tickHist[SYNC_STAGES-1:0], slowTick};
  end

  assign tickEdge = tickHist[SYNC_STAGES-1] & ~tickHist[SYNC_STAGES];
  assign frozen   = haltEn & haltReq;
  assign alignNow = syncBusy & tickEdge & ~resyncWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre         <= '0;
      initialised <= 1'b0;
      syncBusy    <= 1'b1;
    end else begin
      if (resyncWr)      syncBusy <= 1'b1;
      else if (alignNow) syncBusy <= 1'b0;

      if (alignNow) begin
        pre         <= '0;
        initialised <= 1'b1;
      end else if (initialised && !frozen) begin
        pre <= (pre == PRE_LAST) ? '0 : pre + PRE_W'(1);
      end
    end
  end

  assign strobe.step = initialised & ~frozen & ~alignNow & (pre == PRE_LAST);
  assign running     = initialised & ~frozen;

  // R6: a resync request always leaves an alignment pending
  a_r6_resync_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    resyncWr |=> syncBusy) else $error("resync did not set busy");

  // R3: once aligned the time base stays initialised
  a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initialised |=> initialised) else $error("initialised dropped");

  // R3: the prescaler restarts after each step
  a_r3_step_restarts_prescaler: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (pre == '0)) else $error("prescaler not restarted");

  // R8: a freeze holds the prescaler phase
  a_r8_freeze_holds_phase: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !alignNow) |=> $stable(pre)) else $error("phase moved while frozen");
endmodule

// File: rtl/systime_dp.sv
module systime_dp
  import systime_pkg::*;
#(
  parameter int VIEW_W   = 32,
  parameter int SEL_W    = 16,
  parameter int SEL_BASE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic              selWe,
  input  logic [SEL_W-1:0]  selWdata,
  output logic [VIEW_W-1:0] fineView,
  output logic [VIEW_W-1:0] coarseView,
  output logic              timeEvent,
  output logic              ovfPulse
);
  localparam int CNT_W = VIEW_W + SEL_BASE;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] picks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= strobe.step & (&count);
      if (strobe.step) count <= count + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      selReg <= '0;
    else if (selWe) selReg <= selWdata;
  end

  for (genvar k = 0; k < SEL_W; k++) begin : g_pick
    assign picks[k] = selReg[k] & count[k + SEL_BASE];
  end

  assign timeEvent  = |picks;
  assign fineView   = count[VIEW_W-1:0];
  assign coarseView = count[CNT_W-1:SEL_BASE];

  // R3: each step adds exactly one
  a_r3_step_adds_one: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (count == $past(count) + CNT_ONE)) else $error("bad increment");

  // R8: without a step the count holds
  a_r8_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(count)) else $error("count moved without step");

  // R10: the overflow pulse coincides with the zero count
  a_r10_ovf_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (count == '0)) else $error("overflow away from zero");

  // R10: the overflow pulse lasts a single cycle
  a_r10_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse) else $error("overflow longer than one cycle");

  // R5: an empty select keeps the event low
  a_r5_empty_select_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (selReg == '0) |-> !timeEvent) else $error("event with empty select");
endmodule

// File: rtl/sys_time_base.sv
module sys_time_base
  import systime_pkg::*;
#(
  parameter int VIEW_W      = 32,
  parameter int SEL_W       = 16,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              resyncWr,
  input  logic              haltEn,
  input  logic              haltReq,
  input  logic              selWe,
  input  logic [SEL_W-1:0]  selWdata,
  output logic [VIEW_W-1:0] fineView,
  output logic [VIEW_W-1:0] coarseView,
  output logic              timeEvent,
  output logic              ovfPulse,
  output logic              syncBusy,
  output logic              running
);
  ctrl_strobe_t strobe;

  systime_ctrl #(
    .PRESCALE   (PRESCALE),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .slowTick(slowTick),
    .resyncWr(resyncWr),
    .haltEn  (haltEn),
    .haltReq (haltReq),
    .strobe  (strobe),
    .syncBusy(syncBusy),
    .running (running)
  );

  systime_dp #(
    .VIEW_W  (VIEW_W),
    .SEL_W   (SEL_W),
    .SEL_BASE(2)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .selWe     (selWe),
    .selWdata  (selWdata),
    .fineView  (fineView),
    .coarseView(coarseView),
    .timeEvent (timeEvent),
    .ovfPulse  (ovfPulse)
  );
endmodule

// File: tb/tb_sys_time_base.sv
module tb_sys_time_base;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        resyncWr = 1'b0;
  logic        haltEn = 1'b0;
  logic        haltReq = 1'b0;
  logic        selWe = 1'b0;
  logic [15:0] selWdata = '0;
  logic [31:0] fineView, coarseView;
  logic        timeEvent, ovfPulse, syncBusy, running;
  logic [7:0]  fineS, coarseS;
  logic        evS, ovfS, busyS, runS;

  sys_time_base dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .resyncWr(resyncWr),
    .haltEn(haltEn), .haltReq(haltReq), .selWe(selWe), .selWdata(selWdata),
    .fineView(fineView), .coarseView(coarseView), .timeEvent(timeEvent),
    .ovfPulse(ovfPulse), .syncBusy(syncBusy), .running(running)
  );

  // narrow copy that wraps within the run
  sys_time_base #(.VIEW_W(8), .SEL_W(4)) dutOvf (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .resyncWr(1'b0),
    .haltEn(1'b0), .haltReq(1'b0), .selWe(1'b0), .selWdata(4'h0),
    .fineView(fineS), .coarseView(coarseS), .timeEvent(evS),
    .ovfPulse(ovfS), .syncBusy(busyS), .running(runS)
  );

  int compared = 0;
  int mismatched = 0;
  int ovfCount = 0;
  int cyc = 0;
  int alignCyc = -1;
  string fineTag = "R4";

  // reference model built from the requirements
  logic [33:0] mCnt;
  logic [3:0]  mPre;
  logic        mBusy, mInit;
  logic [2:0]  mHist;
  logic [15:0] mSel;
  logic        mAct;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      mCnt <= '0; mPre <= '0; mBusy <= 1'b1; mInit <= 1'b0; mHist <= '0; mSel <= '0;
    end else begin
      mAct = mBusy & mHist[1] & ~mHist[2] & ~resyncWr;
      mHist <= {mHist[1:0], slowTick};
      if (selWe) mSel <= selWdata;
      if (resyncWr) mBusy <= 1'b1; else if (mAct) mBusy <= 1'b0;
      if (mAct) begin
        mPre <= '0; mInit <= 1'b1;
        if (alignCyc < 0) alignCyc <= cyc + 1;
      end else if (mInit && !(haltEn && haltReq)) begin
        if (mPre == 4'd11) begin mPre <= '0; mCnt <= mCnt + 34'd1; end
        else mPre <= mPre + 4'd1;
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(fineTag, "fine view", fineView, mCnt[31:0]);
    chk("R4", "coarse view", coarseView, mCnt[33:2]);
    chk("R6", "sync busy", syncBusy, mBusy);
    chk("R7", "running", running, mInit & ~(haltEn & haltReq));
    chk("R5", "time event", timeEvent, |(mCnt[17:2] & mSel));
    chk("R10", "wide overflow quiet", ovfPulse, 0);
    if (ovfS) begin
      ovfCount++;
      chk("R10", "narrow view at wrap", {coarseS, fineS}, 0);
      chk("R10", "narrow wrap cycle", cyc, alignCyc + 12 * 1024);
    end
  endtask

  task automatic cyc1();
    @(negedge clk);
    if (rstN) compareAll();
  endtask

  bit finished = 0;

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    int haltLeft;
    void'($urandom(32'h5eed_0101));
    haltLeft = 0;
    // R1: reset values
    repeat (4) @(negedge clk);
    chk("R1", "fine at reset", fineView, 0);
    chk("R1", "busy at reset", syncBusy, 1);
    chk("R1", "running at reset", running, 0);
    chk("R1", "event at reset", timeEvent, 0);
    chk("R1", "overflow at reset", ovfPulse, 0);
    rstN = 1'b1;
    // R2: no counting before alignment
    repeat (40) cyc1();
    chk("R2", "fine before align", fineView, 0);
    chk("R2", "running before align", running, 0);
    // R3: align two edges after first high sample
    slowTick = 1'b1;
    cyc1(); chk("R3", "busy edge k", syncBusy, 1);
    cyc1(); chk("R3", "busy edge k+1", syncBusy, 1);
    cyc1(); chk("R3", "busy edge k+2", syncBusy, 0);
    chk("R3", "running after align", running, 1);
    repeat (11) cyc1();
    chk("R3", "no step before 12", fineView, 0);
    cyc1();
    chk("R3", "first step at 12", fineView, 1);
    // R5: single and multiple select bits, then empty
    selWe = 1'b1; selWdata = 16'h0001; cyc1(); selWe = 1'b0;
    repeat (60) cyc1();
    selWe = 1'b1; selWdata = 16'h0003; cyc1(); selWe = 1'b0;
    repeat (60) cyc1();
    selWe = 1'b1; selWdata = 16'h0000; cyc1(); selWe = 1'b0;
    repeat (60) begin cyc1(); chk("R5", "empty select", timeEvent, 0); end
    // R8: freeze
    haltEn = 1'b1; haltReq = 1'b1; fineTag = "R8";
    cyc1(); snap = fineView;
    repeat (50) cyc1();
    chk("R8", "count frozen", fineView, snap);
    chk("R8", "running while frozen", running, 0);
    haltReq = 1'b0;
    repeat (30) cyc1();
    // R9: halt ignored when not enabled
    haltEn = 1'b0; haltReq = 1'b1; fineTag = "R9";
    cyc1(); snap = fineView;
    repeat (36) cyc1();
    chk("R9", "count advances", fineView, snap + 3);
    haltReq = 1'b0;
    // R6: resync keeps value, sets busy; edges while idle ignored
    fineTag = "R6";
    resyncWr = 1'b1; snap = fineView; cyc1(); resyncWr = 1'b0;
    chk("R6", "busy after resync", syncBusy, 1);
    slowTick = 1'b0;
    repeat (9) cyc1();
    chk("R6", "count kept through resync", fineView >= snap, 1);
    slowTick = 1'b1;
    repeat (20) cyc1();
    chk("R6", "realigned", syncBusy, 0);
    slowTick = 1'b0; repeat (10) cyc1();
    slowTick = 1'b1; repeat (40) cyc1();
    // random phase
    fineTag = "R4";
    for (int i = 0; i < 16000; i++) begin
      slowTick = (i % 366) < 183;
      resyncWr = ($urandom_range(0, 399) == 0);
      selWe = ($urandom_range(0, 149) == 0);
      selWdata = 16'($urandom);
      if (haltLeft > 0) haltLeft--;
      else if ($urandom_range(0, 299) == 0) begin
        haltLeft = $urandom_range(5, 60);
        haltEn = 1'($urandom_range(0, 1));
      end
      haltReq = (haltLeft > 0);
      cyc1();
    end
    resyncWr = 1'b0; selWe = 1'b0; haltReq = 1'b0;
    cyc1();
    chk("R10", "narrow wrap count", ovfCount, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule